// File: doc/BRIEF.md
# Unlock-Gated Banked Indirect Register Port

This block is a management-side register slave. It decodes simple read and write strobes carrying a 5-bit register address and 16-bit data, such as a serial management frame decoder would produce. Three of the direct addresses are implemented: a test-control register, a read-data register and a write-data register. Behind them sit hidden extended register banks, each of up to 32 sixteen-bit registers. These are kept as small internal arrays for banks 0, 1 and 3. Bank 2 has no storage.

The extended banks stay locked until software writes the control register with a fixed four-step pattern. Once the banks are open, a control write that carries test mode, a bank and an address does one of two things. With the read bit set, it copies an extended register into the read-data register. With the write bit set, it commits the staged write-data value into an extended register. Writing zero to the control register locks the banks again.

Top module: `ext_bank_port`

## Requirements
- R1: After reset every register reads zero. A direct read (rd_en high with an address) returns data on rdata in the cycle after the strobe. Address 20 returns the last value written to the control register, address 23 the staged write-data value, address 21 the read-data register, and any other address zero.
- R2: The banks open only after four consecutive control writes of 0x0000, 0x0400, 0x0000 and 0x0400, where bit 10 is test mode. Writes to other addresses between these steps neither count as steps nor break the pattern.
- R3: A control write of 0x0000 locks the banks. A command issued after that is ignored until the pattern is repeated.
- R4: While the banks are open, a control write with bit 15 (read) and bit 10 set copies the extended register at bank bits 12:11 and address bits 9:5 into the read-data register at address 21. That register keeps the value until the next control write with bit 15 set.
- R5: A write to address 23 stages a value. While the banks are open, a control write with bit 14 (write) and bit 10 set commits the staged value to the extended register at bank bits 12:11 and address bits 4:0.
- R6: A command issued while the banks are locked, or without bit 10 set, leaves every extended register unchanged. If it has bit 15 set, it clears the read-data register to zero.
- R7: A control write that does not match the next expected step of the pattern returns the tracker to its start, so the full four-step pattern is needed again.
- R8: A command aimed at bank 2 stores nothing and reads back zero. Banks 0, 1 and 3 each hold 32 independent registers.
- R9: Commands do not lock the banks. The banks stay open until a zero control write or reset.
- R10: A single command with both bit 15 and bit 14 set, aimed at the same register, returns the contents from before the write and then commits the staged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Direct register write strobe |
| rd_en | input | 1 | Direct register read strobe |
| addr | input | 5 | Direct register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |

## Verification
A read and a write of the same extended register can fall in one cycle, because a single control word may carry both command bits. The bench stages a new value and issues a combined command at a register holding a known value. It then expects the read-data register to show the old value, and a follow-up read to show the new value. The end of the unlock pattern and a command are also close neighbours. The bench issues a command on the write right after the unlock completes, and again on a write that breaks the pattern, and judges each case by the read-data value.

// File: rtl/ebp_pkg.sv
package ebp_pkg;
  localparam int CW = 16;
  localparam logic [CW-1:0] TM_ONLY = 16'h0400;

  function automatic logic f_rd(input logic [CW-1:0] v);
    return v[15];
  endfunction
  function automatic logic f_wr(input logic [CW-1:0] v);
    return v[14];
  endfunction
  function automatic logic [1:0] f_bank(input logic [CW-1:0] v);
    return v[12:11];
  endfunction
  function automatic logic f_tm(input logic [CW-1:0] v);
    return v[10];
  endfunction
  function automatic logic [4:0] f_raddr(input logic [CW-1:0] v);
    return v[9:5];
  endfunction
  function automatic logic [4:0] f_waddr(input logic [CW-1:0] v);
    return v[4:0];
  endfunction

  typedef enum logic [2:0] {
    UL_IDLE, UL_Z1, UL_T1, UL_Z2, UL_OPEN
  } unlock_t;
endpackage

// File: rtl/ebp_unlock.sv
module ebp_unlock
  import ebp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [CW-1:0] ctrl_val,
  output logic          open
);
  unlock_t st_q, st_d;
  logic is_zero, is_tm;

  assign is_zero = (ctrl_val == '0);
  assign is_tm   = (ctrl_val == TM_ONLY);

  always_comb begin
    st_d = st_q;
    if (ctrl_we) begin
      unique case (st_q)
        UL_IDLE: st_d = is_zero ? UL_Z1   : UL_IDLE;
        UL_Z1:   st_d = is_tm   ? UL_T1   : UL_IDLE;
        UL_T1:   st_d = is_zero ? UL_Z2   : UL_IDLE;
        UL_Z2:   st_d = is_tm   ? UL_OPEN : UL_IDLE;
        UL_OPEN: st_d = is_zero ? UL_IDLE : UL_OPEN;
        default: st_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end

  assign open = (st_q == UL_OPEN);

  AST_OPEN_VIA_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(ctrl_we && ctrl_val == TM_ONLY)); // R2
  AST_ZERO_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && is_zero |=> !open); // R3
  AST_CMD_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    open && !(ctrl_we && is_zero) |=> open); // R9
  AST_BREAK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && !open && !is_zero && !is_tm |=> st_q == UL_IDLE); // R7
endmodule

// File: rtl/ebp_bank_store.sv
module ebp_bank_store #(
  parameter int DW          = 16,
  parameter int AW          = 5,
  parameter int BW          = 2,
  parameter int UNUSED_BANK = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [BW-1:0] wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [BW-1:0] rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int NB    = 1 << BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] bank_rd [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    if (b == UNUSED_BANK) begin : g_hole
      assign bank_rd[b] = '0;
    end else begin : g_mem
      logic [DW-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_fire && wr_bank == BW'(b)) begin
          mem[wr_addr] <= wr_data;
        end
      end
      assign bank_rd[b] = mem[rd_addr];
    end
  end

  assign rd_data = bank_rd[rd_bank];

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bank == BW'(UNUSED_BANK) |-> rd_data == '0); // R8
endmodule

// File: rtl/ext_bank_port.sv
module ext_bank_port
  import ebp_pkg::*;
#(
  parameter int          AW          = 5,
  parameter int          BW          = 2,
  parameter int          UNUSED_BANK = 2,
  parameter logic [4:0]  CTRL_ADDR   = 5'd20,
  parameter logic [4:0]  RDAT_ADDR   = 5'd21,
  parameter logic [4:0]  WDAT_ADDR   = 5'd23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [4:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata
);
  logic [CW-1:0] ctrl_q, stage_q, rdreg_q, store_rd;
  logic          open, ctrl_we, cmd_ok, rd_fire, wr_fire, rd_cmd;

  assign ctrl_we = wr_en && addr == CTRL_ADDR;
  assign cmd_ok  = ctrl_we && open && f_tm(wdata);
  assign rd_cmd  = ctrl_we && f_rd(wdata);
  assign rd_fire = cmd_ok && f_rd(wdata);
  assign wr_fire = cmd_ok && f_wr(wdata);

  ebp_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_val(wdata), .open(open)
  );

  ebp_bank_store #(.DW(CW), .AW(AW), .BW(BW), .UNUSED_BANK(UNUSED_BANK)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_bank(f_bank(wdata)), .wr_addr(f_waddr(wdata)),
    .wr_data(stage_q),
    .rd_bank(f_bank(wdata)), .rd_addr(f_raddr(wdata)), .rd_data(store_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      stage_q <= '0;
      rdreg_q <= '0;
      rdata   <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      if (wr_en && addr == WDAT_ADDR) stage_q <= wdata;
      if (rd_cmd) rdreg_q <= rd_fire ? store_rd : '0;
      if (rd_en) begin
        unique case (addr)
          CTRL_ADDR: rdata <= ctrl_q;
          RDAT_ADDR: rdata <= rdreg_q;
          WDAT_ADDR: rdata <= stage_q;
          default:   rdata <= '0;
        endcase
      end
    end
  end

  AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd && !open |=> rdreg_q == '0); // R6
  AST_NO_TM_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd && !f_tm(wdata) |=> rdreg_q == '0); // R6
  AST_BANK_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && f_bank(wdata) == BW'(UNUSED_BANK) |=> rdreg_q == '0); // R8
  AST_RDREG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cmd |=> $stable(rdreg_q)); // R4
endmodule

// File: tb/ext_bank_port_test.sv
module ext_bank_port_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_bank_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  localparam logic [15:0] TM = 16'h0400;

  function automatic logic [15:0] rcmd(input int b, input int r);
    return 16'h8000 | TM | 16'(b << 11) | 16'(r << 5);
  endfunction
  function automatic logic [15:0] wcmd(input int b, input int r);
    return 16'h4000 | TM | 16'(b << 11) | 16'(r);
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic unlock();
    wr(20, 0); wr(20, TM); wr(20, 0); wr(20, TM);
  endtask

  task automatic ext_read(input int b, input int r, input string req, input logic [15:0] exp);
    logic [15:0] v;
    wr(20, rcmd(b, r)); rd(21, v); check(req, v, exp);
  endtask

  task automatic ext_write(input int b, input int r, input logic [15:0] d);
    wr(23, d); wr(20, wcmd(b, r));
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(20, v); check("R1 ctrl reset", v, 0);
    rd(21, v); check("R1 rdata reset", v, 0);
    rd(23, v); check("R1 wdata reset", v, 0);
    wr(22, 16'hFFFF); rd(22, v); check("R1 unused addr", v, 0);
  endtask

  task automatic t_locked();
    logic [15:0] v;
    ext_write(3, 16'h1B, 16'hBEEF);
    rd(20, v); check("R1 ctrl readback", v, wcmd(3, 16'h1B));
    rd(23, v); check("R1 staged readback", v, 16'hBEEF);
    ext_read(3, 16'h1B, "R6 locked read zero", 0);
    unlock();
    ext_read(3, 16'h1B, "R6 locked write ignored", 0);
    wr(20, 0);
  endtask

  task automatic t_write_read();
    unlock();
    ext_write(3, 16'h1B, 16'h0005);
    ext_write(3, 16'h1D, 16'h029A);
    ext_write(3, 16'h1C, 16'hAAAA);
    ext_write(1, 16'h0C, 16'h1000);
    ext_read(3, 16'h1B, "R5 bank3 1B", 16'h0005);
    ext_read(3, 16'h1C, "R4 bank3 1C", 16'hAAAA);
    ext_read(3, 16'h1D, "R5 bank3 1D", 16'h029A);
    ext_read(1, 16'h0C, "R4 bank1 0C", 16'h1000);
    ext_read(0, 16'h1B, "R8 bank0 independent", 0);
    ext_write(0, 31, 16'h7777);
    ext_read(0, 31, "R8 bank0 top reg", 16'h7777);
    ext_read(3, 31, "R8 bank3 untouched", 0);
  endtask

  task automatic t_no_tm();
    logic [15:0] v;
    ext_read(1, 16'h0C, "R9 still open", 16'h1000);
    wr(23, 16'h3333); wr(20, 16'h4000 | 16'(1 << 11) | 16'h0C);
    wr(20, 16'h8000 | 16'(1 << 11) | 16'(16'h0C << 5));
    rd(21, v); check("R6 no-tm read zero", v, 0);
    ext_read(1, 16'h0C, "R6 no-tm write ignored", 16'h1000);
  endtask

  task automatic t_bank2();
    ext_write(2, 5, 16'h1234);
    ext_read(2, 5, "R8 bank2 zero", 0);
    ext_read(0, 5, "R8 bank2 no alias", 0);
  endtask

  task automatic t_both();
    logic [15:0] v;
    wr(23, 16'h5555);
    wr(20, rcmd(1, 16'h0C) | wcmd(1, 16'h0C));
    rd(21, v); check("R10 old value", v, 16'h1000);
    ext_read(1, 16'h0C, "R10 new value", 16'h5555);
  endtask

  task automatic t_close();
    wr(20, 0);
    ext_read(1, 16'h0C, "R3 closed read zero", 0);
    unlock();
    ext_read(1, 16'h0C, "R3 reopen keeps data", 16'h5555);
    ext_read(3, 16'h1C, "R9 open after cmds", 16'hAAAA);
  endtask

  task automatic t_broken();
    wr(20, 0);
    wr(20, 0); wr(20, TM); wr(20, TM); wr(20, 0); wr(20, TM);
    ext_read(3, 16'h1B, "R7 broken stays locked", 0);
    wr(20, 0); wr(23, 16'h0101); wr(20, TM); wr(22, 16'h9999);
    wr(20, 0); wr(20, TM);
    ext_read(3, 16'h1B, "R2 other addr no break", 16'h0005);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_locked();
    t_write_read();
    t_no_tm();
    t_bank2();
    t_both();
    t_close();
    t_broken();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule